// File: doc/BRIEF.md
# Tuner Control Register Slave

This block sits between a two-wire serial bus and the configuration inputs of a tuner. It samples SCL and SDA in the system clock domain and finds START and STOP conditions. It answers one 7-bit device address, and a strap pin selects the lowest bit of that address. It holds twelve writable configuration bytes and presents them to the tuner on one flat vector. It also returns two read-only status bytes built from live status inputs.

A host writes by sending a register pointer followed by any number of data bytes. A host reads by setting the pointer in a write phase, issuing a repeated START, and clocking bytes out. Each byte it writes or reads moves the pointer to the next register, and the pointer wraps after the last status byte. A data byte written to register 0x04 produces a one-cycle tuning request. Bit 7 of status byte 0x0C reports that the block has been reset. That bit stays set until the host has read 0x0C in a transaction that it closes with STOP.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The device address is 1100000 with its lowest bit replaced by `addr_sel`. With `addr_sel`=0 the block answers 0xC0 (write) and 0xC1 (read); with `addr_sel`=1 it answers 0xC2 and 0xC3. Any other address byte gets a NACK, and the block ignores the rest of that transaction.
- R2: After reset, registers 0x00 to 0x0B hold 0x80, 0x23, 0x02, 0xF6, 0x84, 0x01, 0xC0, 0xC8, 0x4B, 0x00, 0x00 and 0x08. Register i appears on `cfg_o[8*i+7:8*i]`.
- R3: A write sends the address byte with R/W=0, then the pointer (its low four bits are used), then data bytes. Each data byte is stored in the register the pointer selects, and the pointer then advances by one. The block ACKs every byte by pulling SDA low through the ninth clock.
- R4: A read sets the pointer in a write phase and then sends a repeated START with R/W=1. The block returns bytes MSB first and advances the pointer after each one. A master ACK requests the next byte. A master NACK ends the transfer, and the block then releases SDA.
- R5: Status bit 0x0C[7] is 1 after reset. It reads 0 only after register 0x0C has been read in a transaction that ended with STOP. Reads of other registers leave it set.
- R6: Register 0x0C reads as {status bit, `stat_a_i[6:0]`} and register 0x0D reads as `stat_b_i`. The block ACKs data bytes written to 0x0C and 0x0D and discards them.
- R7: `tune_o` pulses high for exactly one clock for each data byte written to register 0x04. It stays low for writes to every other register.
- R8: The pointer wraps from 0x0D to 0x00, on both reads and writes.
- R9: `sda_oe` high means SDA is pulled low. The block changes it only while SCL is low, and `sda_oe` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap for the lowest device address bit |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled |
| sda_oe | output | 1 | Pull SDA low when high |
| stat_a_i | input | 7 | Status bits 6:0 of register 0x0C |
| stat_b_i | input | 8 | Contents of register 0x0D |
| cfg_o | output | 96 | Twelve configuration bytes, register i at bits 8i+7:8i |
| tune_o | output | 1 | One-cycle pulse on each write to register 0x04 |

## Verification
The assertions assume that each high and low phase of SCL lasts several system clocks, longer than the three-flop sampling chain. They also assume that SDA moves only while SCL is low, except at START and STOP, and that the master never sends START or STOP while the block holds SDA low. Under those conditions every change of `sda_oe` and of `cfg_o` follows a detected SCL fall, and so falls inside a low phase. The stimulus holds every bus phase for eight clocks. It changes data only in the middle of a low phase and releases SDA in every bit the slave drives.

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs #(
  parameter logic [6:0] BASE_ADDR = 7'b1100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_sel,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [6:0]  stat_a_i,
  input  logic [7:0]  stat_b_i,
  output logic [95:0] cfg_o,
  output logic        tune_o
);
  localparam logic [3:0] NWR  = 4'd12;
  localparam logic [3:0] LAST = 4'd13;
  localparam logic [95:0] RST_VAL = {8'h08, 8'h00, 8'h00, 8'h4B, 8'hC8, 8'hC0,
                                     8'h01, 8'h84, 8'hF6, 8'h02, 8'h23, 8'h80};

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_PTR, S_WR, S_RD} st_t;

  st_t         st;
  logic [2:0]  scl_s, sda_s;
  logic [3:0]  cnt, ptr;
  logic [7:0]  sh, tx, rd_byte;
  logic [95:0] cfg_q;
  logic        rw, oe, por, rd_stat, tune;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire [6:0] dev_addr = {BASE_ADDR[6:1], addr_sel};
  wire [3:0] nxt = (ptr >= LAST) ? 4'd0 : ptr + 4'd1;
  wire do_load = scl_fall && !start_c && !stop_c && cnt == 4'd9 &&
                 (st == S_RD || (st == S_ADR && rw));

  always_comb begin
    if (ptr < NWR)       rd_byte = cfg_q[{ptr, 3'b000} +: 8];
    else if (ptr == NWR) rd_byte = {por, stat_a_i};
    else if (ptr == LAST) rd_byte = stat_b_i;
    else                 rd_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s   <= 3'b111;
      sda_s   <= 3'b111;
      st      <= S_IDLE;
      cnt     <= '0;
      ptr     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      oe      <= 1'b0;
      por     <= 1'b1;
      rd_stat <= 1'b0;
      tune    <= 1'b0;
      cfg_q   <= RST_VAL;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      tune  <= 1'b0;
      if (start_c) begin
        st  <= S_ADR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_c) begin
        st      <= S_IDLE;
        oe      <= 1'b0;
        rd_stat <= 1'b0;
        if (rd_stat) por <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s[1]};
          if (st == S_RD && cnt == 4'd8 && sda_s[1]) st <= S_IDLE;
        end else if (scl_fall) begin
          if (st == S_RD) begin
            if (cnt == 4'd8) oe <= 1'b0;
            else if (cnt != 4'd0 && cnt != 4'd9) begin
              tx <= {tx[6:0], 1'b0};
              oe <= ~tx[6];
            end
          end else if (cnt == 4'd8) begin
            oe <= 1'b1;
            case (st)
              S_ADR: if (sh[7:1] != dev_addr) begin
                       oe <= 1'b0;
                       st <= S_IDLE;
                     end else rw <= sh[0];
              S_PTR: ptr <= sh[3:0];
              S_WR: begin
                if (ptr < NWR) cfg_q[{ptr, 3'b000} +: 8] <= sh;
                if (ptr == 4'd4) tune <= 1'b1;
                ptr <= nxt;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            oe <= 1'b0;
            case (st)
              S_ADR:   st <= rw ? S_RD : S_PTR;
              S_PTR:   st <= S_WR;
              default: ;
            endcase
          end
          if (cnt == 4'd9) cnt <= '0;
          if (do_load) begin
            tx  <= rd_byte;
            oe  <= ~rd_byte[7];
            ptr <= nxt;
            if (ptr == NWR) rd_stat <= 1'b1;
          end
        end
      end
    end
  end

  assign sda_oe = oe;
  assign cfg_o  = cfg_q;
  assign tune_o = tune;
endmodule

module tuner_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        tune_o,
  input logic        por,
  input logic [95:0] cfg_o
);
  // R7
  tune_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_o |=> !tune_o);
  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !$past(scl_i));
  // R3
  cfg_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cfg_o) |-> !$past(scl_i));
  // R5
  por_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por));
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .tune_o(tune_o), .por(por), .cfg_o(cfg_o)
);

// File: tb/tuner_i2c_regs_tb.sv
module tuner_i2c_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_sel = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_oe, tune_o;
  logic [95:0] cfg_o;
  logic [6:0]  stat_a = 7'h35;
  logic [7:0]  stat_b = 8'h9C;
  wire         sda_line = sda_m & ~sda_oe;
  int nchk = 0, nfail = 0, tcount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) if (tune_o) tcount++;

  tuner_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .stat_a_i(stat_a), .stat_b_i(stat_b),
    .cfg_o(cfg_o), .tune_o(tune_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); nack = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv(input logic mnack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = mnack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return cfg_o[8*i +: 8];
  endfunction

  task automatic read_one(input logic [7:0] p, output logic [7:0] b);
    logic n;
    bus_start(); send(8'hC0, n); send(p, n);
    bus_start(); send(8'hC1, n); recv(1'b1, b); bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] exp [12] = '{8'h80, 8'h23, 8'h02, 8'hF6, 8'h84, 8'h01,
                             8'hC0, 8'hC8, 8'h4B, 8'h00, 8'h00, 8'h08};
    for (int i = 0; i < 12; i++) chk("R2 reset value", reg_of(i), exp[i]);
    chk("R9 idle release", sda_oe, 1'b0);
    chk("R7 no pulse at reset", tcount, 0);
  endtask

  task automatic t_addr();
    logic n;
    bus_start(); send(8'hC2, n); chk("R1 foreign address nack", n, 1'b1);
    send(8'h09, n); send(8'h77, n); bus_stop();
    chk("R1 foreign write ignored", reg_of(9), 8'h00);
    bus_start(); send(8'hC0, n); chk("R1 strap low ack", n, 1'b0); bus_stop();
    addr_sel = 1'b1;
    bus_start(); send(8'hC2, n); chk("R1 strap high ack", n, 1'b0); bus_stop();
    bus_start(); send(8'hC0, n); chk("R1 strap high rejects C0", n, 1'b1); bus_stop();
    addr_sel = 1'b0;
    chk("R9 released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_por();
    logic [7:0] b;
    read_one(8'h00, b); chk("R4 single read", b, 8'h80);
    read_one(8'h0C, b); chk("R5 flag set before cleared", b, {1'b1, 7'h35});
    read_one(8'h0C, b); chk("R5 flag cleared after read and stop", b, {1'b0, 7'h35});
  endtask

  task automatic t_write();
    logic n;
    int t0;
    t0 = tcount;
    bus_start(); send(8'hC0, n); send(8'h02, n); chk("R3 pointer ack", n, 1'b0);
    send(8'h11, n); chk("R3 data ack", n, 1'b0);
    send(8'h22, n); send(8'h33, n); chk("R3 last data ack", n, 1'b0);
    bus_stop();
    chk("R3 reg2", reg_of(2), 8'h11);
    chk("R3 reg3", reg_of(3), 8'h22);
    chk("R3 reg4", reg_of(4), 8'h33);
    chk("R7 one pulse for reg4", tcount - t0, 1);
    t0 = tcount;
    bus_start(); send(8'hC0, n); send(8'h03, n); send(8'h44, n); bus_stop();
    chk("R7 no pulse for reg3", tcount - t0, 0);
    chk("R3 reg3 rewritten", reg_of(3), 8'h44);
  endtask

  task automatic t_ro();
    logic n;
    bus_start(); send(8'hC0, n); send(8'h0C, n);
    send(8'hFF, n); chk("R6 write to 0x0C acked", n, 1'b0);
    send(8'h55, n); chk("R6 write to 0x0D acked", n, 1'b0);
    send(8'hA5, n); bus_stop();
    chk("R8 write wraps to reg0", reg_of(0), 8'hA5);
    chk("R6 reg1 untouched", reg_of(1), 8'h23);
  endtask

  task automatic t_read();
    logic n;
    logic [7:0] b;
    stat_b = 8'h9C;
    bus_start(); send(8'hC0, n); send(8'h0B, n);
    bus_start(); send(8'hC1, n); chk("R4 read address ack", n, 1'b0);
    recv(1'b0, b); chk("R4 reg11", b, 8'h08);
    recv(1'b0, b); chk("R6 status byte 0x0C", b, {1'b0, 7'h35});
    recv(1'b0, b); chk("R6 status byte 0x0D", b, 8'h9C);
    recv(1'b1, b); chk("R8 read wraps to reg0", b, 8'hA5);
    chk("R4 released after nack", sda_oe, 1'b0);
    bus_stop();
    chk("R9 idle after read", sda_oe, 1'b0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    wq();
    t_reset();
    t_addr();
    t_por();
    t_write();
    t_ro();
    t_read();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule